// File: doc/BRIEF.md
# Reloading Down-Counter System Timer

This block is a periodic timer that sits beside a processor core and is reached through a small register read/write bus. Software loads a reload value, then clears the count by writing the current-value register. It starts the timer by setting the run bit in the control register. The counter then decrements on every selected tick, either every core clock or each pulse of an external reference tick enable. When a countdown reaches zero, a sticky wrap flag is set and, if the interrupt-enable bit is set, a one-cycle interrupt request pulse is raised. The counter then reloads and runs again.

A write to the current-value register always clears the count and the wrap flag, whatever the data and whatever the run state. It also marks the counter so that its next active tick loads the reload value afresh. A 0-to-1 change of the run bit marks the counter the same way. Each period therefore starts from the reload value present when counting actually begins, and never from a stale value or an old reload setting. The wrap flag can only come from a real countdown from that value.

Top module: `tick_timer`

## Requirements
- R1: A write to the current-value register (offset 0x8) clears the count and the wrap flag in the following cycle, whatever the written data. A read of the current-value register then returns 0.
- R2: After a current-value write, the next active tick loads the reload value, so the first wrap comes reload+1 ticks after that load's predecessor write.
- R3: A current-value write never produces an interrupt pulse. If it lands in the same cycle as a wrapping tick, the write wins: no pulse, and the flag stays clear.
- R4: When the run bit (control bit 0) goes from 0 to 1, the first tick loads the reload value present at that moment. With the core clock selected, the first interrupt pulse follows the enabling write edge by reload+1 cycles.
- R5: A current-value write while the timer is stopped is honoured. While stopped, the count does not change and the wrap flag is never set.
- R6: The wrap flag is set only by a tick that takes the count from 1 to 0. A reload value of 0 leaves the counter idle at 0, with no flag and no interrupt.
- R7: Control register layout at offset 0x0: bit 0 run, bit 1 interrupt enable, bit 2 source select (1 = core clock), bit 16 wrap flag (read only). The reload register is at offset 0x4. Writing 0x7 starts counting on the core clock with interrupts.
- R8: With source select at 0, the counter advances only on cycles where `ref_tick` is high.
- R9: A reload value of N gives one wrap every N+1 source ticks.
- R10: Reading the control register clears the wrap flag. A wrap in the same cycle as that read wins, so the flag reads 1 on the next read.
- R11: The reload and current-value registers are 24 bits wide. Bits 31:24 read as 0, and written upper bits are ignored.
- R12: `irq` is a pulse exactly one cycle wide on each wrap, and only while interrupt enable is set. With interrupt enable clear, the flag is still set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| ref_tick | input | 1 | External reference tick enable, one core cycle wide |
| irq | output | 1 | Interrupt request pulse |

## Verification
Two pairs of functions can coincide in one cycle. The first is a current-value write landing on the very clock edge where the countdown goes from 1 to 0. The bench starts a known reload value, counts edges from the enabling write, and times the clearing write to that edge. It then expects no pulse, a clear flag, a zero count, and a full fresh period afterwards. The second is a control-register read landing on a wrapping edge. There the bench expects the read to return the old clear flag, the next read to return 1, and a third read to return 0.

// File: rtl/tick_timer_pkg.sv
// Shared constants and types of the reloading down-counter timer.
// Register offsets and control bit positions are decoded by software,
// so they are fixed here and used by every module of the block.
package tick_timer_pkg;

    // Register byte offsets on the register bus
    localparam logic [3:0] OFS_CTRL    = 4'h0;
    localparam logic [3:0] OFS_RELOAD  = 4'h4;
    localparam logic [3:0] OFS_CURRENT = 4'h8;

    // Control register bit positions
    localparam int unsigned CTL_RUN_BIT  = 0;
    localparam int unsigned CTL_IE_BIT   = 1;
    localparam int unsigned CTL_SRC_BIT  = 2;
    localparam int unsigned CTL_FLAG_BIT = 16;

    // Writable control state
    typedef struct packed {
        logic src_core;   // 1: count every core clock, 0: count on ref tick
        logic irq_en;     // allow interrupt pulse on wrap
        logic run;        // counter enabled
    } ctl_t;

endpackage

// File: rtl/tick_timer_src.sv
// Tick source selector.
// Produces the single-cycle count enable from the run bit and the
// source select. Assumes ref_tick is already synchronous to clk and
// at most one cycle wide per reference period.
module tick_timer_src (
    input  logic run,
    input  logic src_core,
    input  logic ref_tick,
    output logic tick
);

    // Pick the active source and gate it with the run bit
    always_comb begin
        tick = run & (src_core | ref_tick);
    end

endmodule

// File: rtl/tick_timer_regs.sv
// Register file and bus decode of the timer.
// Holds the control bits and the reload value, decodes the strobes that
// the counter needs (clear, arm on run rise, flag read-clear) and builds
// the read data. Assumes one-cycle accesses with combinational read data.
module tick_timer_regs
    import tick_timer_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              wrap_flag,
    output ctl_t              ctl,
    output logic [CNT_W-1:0]  reload_val,
    output logic              cv_clear,
    output logic              arm_load,
    output logic              flag_rd_clr
);

    localparam int unsigned PAD_W = DATA_W - CNT_W;

    logic hit_ctrl, hit_reload, hit_current;
    logic wr_ctrl, wr_reload;
    logic unused_wdata_hi;

    // Address match for each register
    always_comb begin
        hit_ctrl    = (bus_addr == ADDR_W'(OFS_CTRL));
        hit_reload  = (bus_addr == ADDR_W'(OFS_RELOAD));
        hit_current = (bus_addr == ADDR_W'(OFS_CURRENT));
    end

    // Access strobes handed to the registers and the counter
    always_comb begin
        wr_ctrl     = bus_sel & bus_wr & hit_ctrl;
        wr_reload   = bus_sel & bus_wr & hit_reload;
        cv_clear    = bus_sel & bus_wr & hit_current;
        flag_rd_clr = bus_sel & ~bus_wr & hit_ctrl;
        arm_load    = wr_ctrl & bus_wdata[CTL_RUN_BIT] & ~ctl.run;
    end

    // Control bits: run, interrupt enable, source select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (wr_ctrl) begin
            ctl.run      <= bus_wdata[CTL_RUN_BIT];
            ctl.irq_en   <= bus_wdata[CTL_IE_BIT];
            ctl.src_core <= bus_wdata[CTL_SRC_BIT];
        end
    end

    // Reload value, upper write bits dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_val <= '0;
        end else if (wr_reload) begin
            reload_val <= bus_wdata[CNT_W-1:0];
        end
    end

    // Read data multiplexer, zero outside a read access
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (hit_ctrl) begin
                bus_rdata[CTL_RUN_BIT]  = ctl.run;
                bus_rdata[CTL_IE_BIT]   = ctl.irq_en;
                bus_rdata[CTL_SRC_BIT]  = ctl.src_core;
                bus_rdata[CTL_FLAG_BIT] = wrap_flag;
            end else if (hit_reload) begin
                bus_rdata = {{PAD_W{1'b0}}, reload_val};
            end else if (hit_current) begin
                bus_rdata = {{PAD_W{1'b0}}, cnt_val};
            end
        end
    end

    // Write bits above the counter width have no destination
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];

endmodule

// File: rtl/tick_timer_count.sv
// Down-counter, wrap flag and interrupt pulse of the timer.
// A pending-load mark, set by a current-value write or by the run bit
// rising, makes the next tick load the reload value. A tick at count 0
// also loads. Only a tick taking the count from 1 to 0 is a wrap.
// A current-value write outranks a tick in the same cycle.
module tick_timer_count #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cv_clear,
    input  logic             arm_load,
    input  logic             flag_rd_clr,
    input  logic             irq_en,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt_val,
    output logic             wrap_flag,
    output logic             irq
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic load_pend;
    logic do_load;
    logic wrap_evt;

    // Decode what the current tick does
    always_comb begin
        do_load  = load_pend | (cnt_val == '0);
        wrap_evt = tick & ~cv_clear & ~load_pend & (cnt_val == CNT_ONE);
    end

    // Count register and pending-load mark
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_val   <= '0;
            load_pend <= 1'b0;
        end else if (cv_clear) begin
            cnt_val   <= '0;
            load_pend <= 1'b1;
        end else begin
            if (arm_load) begin
                load_pend <= 1'b1;
            end
            if (tick) begin
                if (do_load) begin
                    cnt_val   <= reload_val;
                    load_pend <= 1'b0;
                end else begin
                    cnt_val <= cnt_val - CNT_ONE;
                end
            end
        end
    end

    // Sticky wrap flag: clear on current-value write, set on wrap, read-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrap_flag <= 1'b0;
        end else if (cv_clear) begin
            wrap_flag <= 1'b0;
        end else if (wrap_evt) begin
            wrap_flag <= 1'b1;
        end else if (flag_rd_clr) begin
            wrap_flag <= 1'b0;
        end
    end

    // One-cycle interrupt pulse per wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= wrap_evt & irq_en;
        end
    end

endmodule

// File: rtl/tick_timer.sv
// Top of the reloading down-counter timer.
// Connects the register file, the tick source selector and the counter.
// Assumes a single clock domain and a synchronous active-low reset.
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ref_tick,
    output logic              irq
);

    ctl_t             ctl;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] cnt_val;
    logic             wrap_flag;
    logic             cv_clear;
    logic             arm_load;
    logic             flag_rd_clr;
    logic             tick;
    logic             run_w;
    logic             irq_en_w;

    // Flatten control fields for the submodules and the checker
    always_comb begin
        run_w    = ctl.run;
        irq_en_w = ctl.irq_en;
    end

    tick_timer_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .cnt_val     (cnt_val),
        .wrap_flag   (wrap_flag),
        .ctl         (ctl),
        .reload_val  (reload_val),
        .cv_clear    (cv_clear),
        .arm_load    (arm_load),
        .flag_rd_clr (flag_rd_clr)
    );

    tick_timer_src src_i (
        .run      (run_w),
        .src_core (ctl.src_core),
        .ref_tick (ref_tick),
        .tick     (tick)
    );

    tick_timer_count #(
        .CNT_W (CNT_W)
    ) count_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .cv_clear    (cv_clear),
        .arm_load    (arm_load),
        .flag_rd_clr (flag_rd_clr),
        .irq_en      (irq_en_w),
        .reload_val  (reload_val),
        .cnt_val     (cnt_val),
        .wrap_flag   (wrap_flag),
        .irq         (irq)
    );

endmodule

// File: rtl/tick_timer_chk.sv
// Property checker for the timer, bound to the top module.
// Observes the bus ports, the interrupt output and the counter state.
module tick_timer_chk
    import tick_timer_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned CNT_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic              tick,
    input logic              run,
    input logic              irq_en,
    input logic [CNT_W-1:0]  cnt,
    input logic              flag
);

    logic cv_wr;
    logic reload_rd;

    // Strobes seen from the bus ports
    always_comb begin
        cv_wr     = bus_sel & bus_wr & (bus_addr == ADDR_W'(OFS_CURRENT));
        reload_rd = bus_sel & ~bus_wr & (bus_addr == ADDR_W'(OFS_RELOAD));
    end

    // R1
    cv_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cv_wr |=> (cnt == '0) && !flag);

    // R3
    cv_write_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cv_wr |=> !irq);

    // R5
    frozen_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cv_wr) |=> $stable(cnt));

    // R6
    flag_from_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(tick) && ($past(cnt) == CNT_W'(1))));

    // R12
    irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R12
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(irq_en));

    // R11
    reload_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_rd |-> (bus_rdata[DATA_W-1:CNT_W] == '0));

endmodule

bind tick_timer tick_timer_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .tick      (tick),
    .run       (run_w),
    .irq_en    (irq_en_w),
    .cnt       (cnt_val),
    .flag      (wrap_flag)
);

// File: tb/tick_timer_tb_top.sv
// Directed bench for the timer: one task per scenario, each checking
// its own results through the bus and the interrupt output.
module tick_timer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int REF_DIV    = 5;
    localparam int WAIT_LIMIT = 400;

    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_RLD  = 4'h4;
    localparam logic [3:0] A_CUR  = 4'h8;
    localparam int FLAG_POS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ref_tick = 1'b0;
    logic        irq;
    logic        ref_on = 1'b0;

    int vectors = 0;
    int fails = 0;

    tick_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ref_tick  (ref_tick),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference tick: one cycle high every REF_DIV cycles while enabled
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            if (ref_on) begin
                ph = (ph + 1) % REF_DIV;
                ref_tick = (ph == 0);
            end else begin
                ph = 0;
                ref_tick = 1'b0;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        @(posedge clk);
        #1;
        bus_sel = 1'b0;
    endtask

    // Edges from now until irq is seen high after an edge
    task automatic edges_to_irq(output int n);
        n = 0;
        do begin
            @(posedge clk);
            #1;
            n++;
        end while (!irq && n < WAIT_LIMIT);
    endtask

    // Pulses seen during a window of edges, plus wider-than-one-cycle check
    task automatic count_irq(input int cycles, output int pulses, output int wide);
        logic prev = 1'b0;
        pulses = 0;
        wide = 0;
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk);
            #1;
            if (irq && !prev) pulses++;
            if (irq && prev) wide++;
            prev = irq;
        end
    endtask

    task automatic stop_timer();
        bus_write(A_CTRL, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R7 reset irq", {31'b0, irq}, 32'h0);
        bus_read(A_CTRL, d);
        check("R7 reset ctrl", d, 32'h0);
        bus_read(A_RLD, d);
        check("R11 reset reload", d, 32'h0);
        bus_read(A_CUR, d);
        check("R1 reset current", d, 32'h0);
    endtask

    task automatic t_core_period();
        int n, p, w;
        bus_write(A_RLD, 32'd3);
        bus_write(A_CUR, 32'h0);
        bus_write(A_CTRL, 32'h7);
        edges_to_irq(n);
        edges_to_irq(n);
        check("R9 period reload 3", n, 32'd4);
        count_irq(40, p, w);
        check("R12 pulses in 40 cycles", p, 32'd10);
        check("R12 pulse width", w, 32'd0);
        stop_timer();
        bus_write(A_RLD, 32'd1);
        bus_write(A_CTRL, 32'h7);
        edges_to_irq(n);
        edges_to_irq(n);
        check("R9 period reload 1", n, 32'd2);
        stop_timer();
    endtask

    task automatic t_cleared_while_stopped();
        logic [31:0] d;
        int n;
        bus_write(A_RLD, 32'd9);
        bus_write(A_CTRL, 32'h7);
        repeat (4) @(posedge clk);
        bus_write(A_CTRL, 32'h6);
        bus_write(A_RLD, 32'd4);
        bus_write(A_CUR, 32'hDEAD_BEEF);
        bus_read(A_CUR, d);
        check("R1 R5 current after stopped write", d, 32'h0);
        bus_read(A_CTRL, d);
        check("R1 flag after stopped write", {31'b0, d[FLAG_POS]}, 32'h0);
        repeat (6) @(posedge clk);
        bus_read(A_CUR, d);
        check("R5 frozen while stopped", d, 32'h0);
        bus_write(A_CTRL, 32'h7);
        edges_to_irq(n);
        check("R4 first wait uses new reload", n, 32'd5);
        edges_to_irq(n);
        check("R2 period after clear", n, 32'd5);
        stop_timer();
    endtask

    task automatic t_restart_stale();
        logic [31:0] d1, d2;
        int n;
        bus_write(A_RLD, 32'd20);
        bus_write(A_CUR, 32'h0);
        bus_write(A_CTRL, 32'h7);
        repeat (7) @(posedge clk);
        bus_write(A_CTRL, 32'h6);
        bus_read(A_CUR, d1);
        repeat (5) @(posedge clk);
        bus_read(A_CUR, d2);
        check("R5 count holds while stopped", d2, d1);
        bus_write(A_RLD, 32'd6);
        bus_write(A_CTRL, 32'h7);
        edges_to_irq(n);
        check("R4 run rise reloads latest value", n, 32'd7);
        stop_timer();
    endtask

    task automatic t_ref_source();
        logic [31:0] d1, d2;
        int n;
        bus_write(A_RLD, 32'd2);
        bus_write(A_CUR, 32'h0);
        bus_write(A_CTRL, 32'h3);
        repeat (3) @(posedge clk);
        bus_read(A_CUR, d1);
        repeat (8) @(posedge clk);
        bus_read(A_CUR, d2);
        check("R8 no count without ref tick", d2, d1);
        ref_on = 1'b1;
        edges_to_irq(n);
        edges_to_irq(n);
        check("R8 R9 period on ref tick", n, 32'd15);
        stop_timer();
        ref_on = 1'b0;
    endtask

    task automatic t_zero_reload();
        logic [31:0] d;
        int p, w;
        bus_write(A_RLD, 32'd0);
        bus_write(A_CUR, 32'h0);
        bus_write(A_CTRL, 32'h7);
        count_irq(20, p, w);
        check("R6 no pulse at reload 0", p, 32'd0);
        bus_read(A_CUR, d);
        check("R6 idle count at reload 0", d, 32'h0);
        bus_read(A_CTRL, d);
        check("R6 no flag at reload 0", {31'b0, d[FLAG_POS]}, 32'h0);
        stop_timer();
    endtask

    task automatic t_write_on_wrap();
        logic [31:0] d;
        int n;
        bus_write(A_RLD, 32'd5);
        bus_write(A_CTRL, 32'h7);
        repeat (5) @(posedge clk);
        bus_write(A_CUR, 32'h0000_0001);
        check("R3 no pulse on colliding write", {31'b0, irq}, 32'h0);
        edges_to_irq(n);
        check("R2 full period after colliding write", n, 32'd6);
        stop_timer();
        bus_write(A_RLD, 32'd5);
        bus_write(A_CTRL, 32'h7);
        repeat (5) @(posedge clk);
        bus_write(A_CUR, 32'h0);
        bus_read(A_CUR, d);
        check("R1 count zero after colliding write", d, 32'h0);
        bus_read(A_CTRL, d);
        check("R3 flag clear after colliding write", {31'b0, d[FLAG_POS]}, 32'h0);
        stop_timer();
    endtask

    task automatic t_read_on_wrap();
        logic [31:0] d;
        bus_write(A_RLD, 32'd5);
        bus_write(A_CUR, 32'h0);
        bus_write(A_CTRL, 32'h7);
        repeat (5) @(posedge clk);
        bus_read(A_CTRL, d);
        check("R10 read before wrap edge", {31'b0, d[FLAG_POS]}, 32'h0);
        check("R7 ctrl bits read back", {29'b0, d[2:0]}, 32'h7);
        bus_read(A_CTRL, d);
        check("R10 wrap wins over read clear", {31'b0, d[FLAG_POS]}, 32'h1);
        bus_read(A_CTRL, d);
        check("R10 read cleared flag", {31'b0, d[FLAG_POS]}, 32'h0);
        stop_timer();
    endtask

    task automatic t_no_irq_enable();
        logic [31:0] d;
        int p, w;
        bus_write(A_RLD, 32'd3);
        bus_write(A_CUR, 32'h0);
        bus_write(A_CTRL, 32'h5);
        count_irq(12, p, w);
        check("R12 no pulse with enable clear", p, 32'd0);
        bus_read(A_CTRL, d);
        check("R12 flag set with enable clear", {31'b0, d[FLAG_POS]}, 32'h1);
        stop_timer();
    endtask

    task automatic t_widths();
        logic [31:0] d;
        bus_write(A_RLD, 32'hFFFF_FFFF);
        bus_read(A_RLD, d);
        check("R11 reload upper bits", d, 32'h00FF_FFFF);
        bus_write(A_CUR, 32'hFFFF_FFFF);
        bus_read(A_CUR, d);
        check("R11 R1 current after write", d, 32'h0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_core_period();
        t_cleared_while_stopped();
        t_restart_stale();
        t_ref_source();
        t_zero_reload();
        t_write_on_wrap();
        t_read_on_wrap();
        t_no_irq_enable();
        t_widths();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule